// File: doc/BRIEF.md
# Clock-Gated Failover Sequencer

This block steers a node between a primary function, held in a region that can be reprogrammed at run time, and a backup function. The backup is always configured but its clock is normally off to save power. A fault trigger starts the backup clock on the next cycle and hands the work to the backup. The sequencer then cuts the primary region off from the system bus and starts an external reconfiguration engine. Once the engine finishes, the block can put the bus controller through a reset and wait for it to rejoin the network. It then returns control to the primary and gates the backup clock again.

The controller keeps receiving bus traffic for the whole failover, and the backup consumes it. The block only sequences the controls. It does not touch the data path or the reconfiguration engine.

The state machine has five states:
- IDLE: healthy; the primary is active and the backup clock is gated.
- BACKUP_ON: a single cycle in which the backup is running and selected and the primary is isolated.
- RECONFIG: the engine has been started and the block waits for it.
- REINTEGRATE: the controller is reset and the block waits for its integrated status.
- RESTORE: a single hand-back cycle.

The transitions are:
- IDLE→BACKUP_ON on a trigger.
- BACKUP_ON→RECONFIG unconditionally.
- RECONFIG→REINTEGRATE on done when reintegration is enabled.
- RECONFIG→RESTORE on done when reintegration is disabled.
- RECONFIG→RECONFIG on an engine error. The backup is held and the error is latched.
- REINTEGRATE→RESTORE on integrated status.
- RESTORE→IDLE unconditionally.

Top module: `failover_seq`

## Requirements
- R1: After reset every output is 0. This means the backup clock is gated, the primary is selected (`sel_backup`=0), the primary is not isolated, no start or controller reset is issued, and both fault flags are clear.
- R2: A `fault_trig` sampled high in IDLE makes `backup_clk_en`, `sel_backup` and `prim_isolate` all 1 on the very next cycle.
- R3: `reconf_start` is a one-cycle pulse. It is issued in the cycle after the backup became active, and only once per failover.
- R4: `prim_isolate` stays 1 from the cycle after the trigger until the cycle after an accepted `reconf_done`.
- R5: With `reint_en`=1, an accepted done leads to REINTEGRATE. In that state `prim_isolate` drops, `cc_reset` pulses for exactly the first cycle, and the backup stays selected. `cc_integrated` is ignored in that first cycle. After that, `cc_integrated` moves the block to RESTORE.
- R6: With `reint_en`=0, an accepted done goes straight to RESTORE and no `cc_reset` is issued.
- R7: In RESTORE, `sel_backup`=0 and `backup_clk_en` is still 1. On the following cycle the block is in IDLE and `backup_clk_en`=0.
- R8: `reconf_err` in RECONFIG takes priority over a simultaneous done. It sets the sticky `reconf_fault` flag and keeps the backup running, selected and the primary isolated. Any later done is then ignored until reset.
- R9: If `cc_integrated` has not been seen, `reint_fail` is set no earlier than TIMEOUT_CYC cycles and no later than TIMEOUT_CYC+2 cycles after the `cc_reset` cycle. The backup stays selected, and a late `cc_integrated` still completes the recovery.
- R10: `fault_trig` in any state other than IDLE has no effect.
- R11: Both fault flags stay set until `rst_n`. A later failover still runs its full sequence while `reint_fail` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_trig | input | 1 | Fault trigger from the status filter or local detector |
| reconf_done | input | 1 | Reconfiguration engine finished |
| reconf_err | input | 1 | Reconfiguration engine failed |
| cc_integrated | input | 1 | Bus controller reports it has rejoined the network |
| reint_en | input | 1 | Configuration: 1 = reset and reintegrate the controller after reconfiguration |
| backup_clk_en | output | 1 | Clock enable of the backup function |
| prim_isolate | output | 1 | Isolates the primary region from the system bus |
| reconf_start | output | 1 | One-cycle start strobe to the reconfiguration engine |
| cc_reset | output | 1 | One-cycle reset of the bus controller |
| sel_backup | output | 1 | Active-function select: 1 = backup, 0 = primary |
| reconf_fault | output | 1 | Sticky reconfiguration error flag |
| reint_fail | output | 1 | Sticky reintegration timeout flag |

## Verification
The bench checks the exact cycle of the clock enable after a trigger. A design with an extra register would show a two-cycle turnaround. It also checks that the start strobe appears only after the backup is live and only once, even when the trigger is repeated mid-sequence. A machine that re-entered on a trigger would issue a second start.

Done and error arriving together must latch the fault and keep isolation. Acceptance of done would release the primary onto the bus. Integrated status held high through the reset cycle must not end reintegration early.

The timeout is bracketed from both sides. A late `cc_integrated` must still hand control back. The run without reintegration must never pulse the controller reset.

// File: rtl/failover_pkg.sv
package failover_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BACKUP_ON,
        ST_RECONFIG,
        ST_REINTEGRATE,
        ST_RESTORE
    } fo_state_e;
endpackage

// File: rtl/fo_sticky.sv
module fo_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
    end

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> flag_o);
endmodule

// File: rtl/fo_wait_timer.sv
module fo_wait_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)             cnt_q <= '0;
        else if (tick_i && cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == LIM);

    // R9
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
endmodule

// File: rtl/failover_seq.sv
module failover_seq
    import failover_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_trig,
    input  logic reconf_done,
    input  logic reconf_err,
    input  logic cc_integrated,
    input  logic reint_en,
    output logic backup_clk_en,
    output logic prim_isolate,
    output logic reconf_start,
    output logic cc_reset,
    output logic sel_backup,
    output logic reconf_fault,
    output logic reint_fail
);
    fo_state_e state_q, state_d;
    logic      entry_q;
    logic      err_set, tmo_expired, in_reint;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            entry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            entry_q <= (state_d != state_q);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (fault_trig) state_d = ST_BACKUP_ON;
            ST_BACKUP_ON:   state_d = ST_RECONFIG;
            ST_RECONFIG:    if (!reconf_fault && !reconf_err && reconf_done)
                                state_d = reint_en ? ST_REINTEGRATE : ST_RESTORE;
            ST_REINTEGRATE: if (!entry_q && cc_integrated) state_d = ST_RESTORE;
            ST_RESTORE:     state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        backup_clk_en = 1'b0;
        prim_isolate  = 1'b0;
        sel_backup    = 1'b0;
        reconf_start  = 1'b0;
        cc_reset      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BACKUP_ON: begin
                backup_clk_en = 1'b1;
                prim_isolate  = 1'b1;
                sel_backup    = 1'b1;
            end
            ST_RECONFIG: begin
                backup_clk_en = 1'b1;
                prim_isolate  = 1'b1;
                sel_backup    = 1'b1;
                reconf_start  = entry_q;
            end
            ST_REINTEGRATE: begin
                backup_clk_en = 1'b1;
                sel_backup    = 1'b1;
                cc_reset      = entry_q;
            end
            ST_RESTORE: backup_clk_en = 1'b1;
            default: ;
        endcase
    end

    assign err_set  = (state_q == ST_RECONFIG) && reconf_err;
    assign in_reint = (state_q == ST_REINTEGRATE);

    fo_sticky u_err_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .flag_o (reconf_fault)
    );

    fo_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (!in_reint),
        .tick_i    (in_reint && !entry_q),
        .expired_o (tmo_expired)
    );

    fo_sticky u_tmo_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tmo_expired),
        .flag_o (reint_fail)
    );

    // R2
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fault_trig) |=> (backup_clk_en && sel_backup && prim_isolate));
    // R3
    start_after_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_start |-> ($past(backup_clk_en) && !$past(reconf_start)));
    // R4
    isolate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prim_isolate) |-> $past(reconf_done && !reconf_err && !reconf_fault));
    // R5
    ctrl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_reset |-> ($past(reconf_done) && $past(reint_en)));
    // R7
    select_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_backup |-> backup_clk_en);
    // R8
    fault_holds_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_fault |-> (sel_backup && prim_isolate));
endmodule

// File: tb/failover_seq_bench.sv
module failover_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_trig = 1'b0, reconf_done = 1'b0, reconf_err = 1'b0;
    logic cc_integrated = 1'b0, reint_en = 1'b1;
    logic backup_clk_en, prim_isolate, reconf_start, cc_reset, sel_backup;
    logic reconf_fault, reint_fail;

    int checks = 0;
    int failures = 0;
    int start_cnt = 0;
    int reset_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    failover_seq #(.TIMEOUT_CYC(TMO)) u_failover_seq (
        .clk(clk), .rst_n(rst_n), .fault_trig(fault_trig), .reconf_done(reconf_done),
        .reconf_err(reconf_err), .cc_integrated(cc_integrated), .reint_en(reint_en),
        .backup_clk_en(backup_clk_en), .prim_isolate(prim_isolate),
        .reconf_start(reconf_start), .cc_reset(cc_reset), .sel_backup(sel_backup),
        .reconf_fault(reconf_fault), .reint_fail(reint_fail)
    );

    always @(negedge clk) begin
        if (reconf_start) start_cnt++;
        if (cc_reset)     reset_cnt++;
    end

    task automatic chk(input string req, input string what, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] outs();
        return {backup_clk_en, prim_isolate, reconf_start, cc_reset, sel_backup, reconf_fault, reint_fail};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        fault_trig = 0; reconf_done = 0; reconf_err = 0; cc_integrated = 0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1", "outputs after reset", outs(), 7'b0000000);
    endtask

    // trigger at negedge n0; sequence per requirements
    task automatic t_reint_path();
        reint_en = 1'b1;
        start_cnt = 0; reset_cnt = 0;
        fault_trig = 1; step(); fault_trig = 0;
        chk("R2", "one-cycle turnaround", outs(), 7'b1100100);
        step();
        chk("R3", "start pulse", outs(), 7'b1110100);
        step();
        chk("R3", "start drops", outs(), 7'b1100100);
        step();
        chk("R4", "isolation held while waiting", outs(), 7'b1100100);
        cc_integrated = 1; reconf_done = 1; step(); reconf_done = 0;
        chk("R5", "reintegrate entry", outs(), 7'b1001100);
        step();
        chk("R5", "integrated ignored in reset cycle", outs(), 7'b1000100);
        cc_integrated = 1; step(); cc_integrated = 0;
        chk("R7", "restore cycle", outs(), 7'b1000000);
        step();
        chk("R7", "back to idle", outs(), 7'b0000000);
        chk("R3", "one start per failover", 7'(start_cnt), 7'd1);
    endtask

    task automatic t_direct_path();
        reint_en = 1'b0;
        reset_cnt = 0;
        fault_trig = 1; step(); fault_trig = 0;
        step(); step();
        reconf_done = 1; step(); reconf_done = 0;
        chk("R6", "restore without reintegration", outs(), 7'b1000000);
        step();
        chk("R6", "idle after direct path", outs(), 7'b0000000);
        chk("R6", "no controller reset", 7'(reset_cnt), 7'd0);
    endtask

    task automatic t_retrigger();
        reint_en = 1'b0;
        start_cnt = 0;
        fault_trig = 1; step();
        step();            // RECONFIG, trigger still high
        step();
        fault_trig = 0;
        reconf_done = 1; step(); reconf_done = 0;
        fault_trig = 1; step(); fault_trig = 0;   // trigger during RESTORE
        chk("R10", "trigger in restore ignored", outs(), 7'b0000000);
        step();
        chk("R10", "still idle", outs(), 7'b0000000);
        chk("R10", "single start despite held trigger", 7'(start_cnt), 7'd1);
    endtask

    task automatic t_error();
        reint_en = 1'b1;
        fault_trig = 1; step(); fault_trig = 0;
        step(); step();
        reconf_err = 1; reconf_done = 1; step(); reconf_err = 0; reconf_done = 0;
        chk("R8", "error beats done", outs(), 7'b1100110);
        reconf_done = 1; step(); reconf_done = 0;
        chk("R8", "later done ignored", outs(), 7'b1100110);
        step(); step();
        chk("R11", "fault flag sticky", outs(), 7'b1100110);
    endtask

    task automatic t_timeout();
        reint_en = 1'b1;
        fault_trig = 1; step(); fault_trig = 0;
        step(); step();
        reconf_done = 1; step(); reconf_done = 0;
        chk("R5", "reset pulse on entry", outs(), 7'b1001100);
        for (int i = 0; i < TMO; i++) step();
        chk("R9", "no flag before limit", outs(), 7'b1000100);
        step(); step(); step();
        chk("R9", "flag after limit", outs(), 7'b1000101);
        cc_integrated = 1; step(); cc_integrated = 0;
        chk("R9", "late integration restores", outs(), 7'b1000001);
        step();
        chk("R11", "timeout flag persists in idle", outs(), 7'b0000001);
        fault_trig = 1; step(); fault_trig = 0;
        chk("R11", "new failover with flag set", outs(), 7'b1100101);
        step();
        chk("R11", "start issued with flag set", outs(), 7'b1110101);
    endtask

    initial begin
        t_reset();
        t_reint_path();
        t_direct_path();
        t_retrigger();
        t_error();
        t_reset();
        t_timeout();
        t_reset();
        chk("R11", "reset clears flags", outs(), 7'b0000000);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule